// File: doc/BRIEF.md
# Keyed Watchdog Timer with Preload

This block is a supervision counter for a small microcontroller. It advances once per machine-cycle enable pulse. When it steps past its all-ones value it raises a system reset request for a fixed number of clock cycles and starts again from zero. Software keeps the system alive by writing a reload register before that happens. The written value lands in the counter's top bits, so the same write both services the timer and sets how long the next timeout is.

A second write target, the key register, can switch the timer off. Only one exact 8-bit pattern does this; every other key value keeps it running. The key resets to a value that leaves the timer enabled, so the watchdog is active from reset onward. The idle-mode input is accepted at the boundary but does not affect counting: the timer and the reset logic keep running while the core is idle.

Top module: `wdog_top`

## Requirements
- R1: While enabled and not being reloaded, the counter advances by one on each cycle where `tick_i` is high. Starting from value S, the reset request rises on the (2^CNT_W − S)-th tick.
- R2: On overflow the counter returns to zero, and `rst_req_o` goes high for exactly PULSE_LEN (default 4) consecutive clock cycles, starting in the cycle after the overflowing tick's clock edge.
- R3: A write with `sel_i`=0 and data from 00h to 7Eh loads data bits [PRE_W-1:0] into the top PRE_W counter bits and clears the lower CNT_W−PRE_W bits.
- R4: A reload write of 00h clears the whole counter, so a full 2^CNT_W ticks are needed for the next overflow.
- R5: A reload write with data 7Fh or above leaves the counter unchanged.
- R6: While the key register holds 55h, the timer is disabled: ticks do not advance the counter and the counter keeps its value.
- R7: Every key value other than 55h enables the timer. The key register resets to 00h, so the timer counts right after reset, and writing another key after 55h resumes counting from the held value.
- R8: `idle_i` has no effect on counting or on the reset request.
- R9: When a valid reload write and a tick fall in the same cycle, the counter takes the reload value and the tick is lost.
- R10: `sel_i`=1 with `wr_i` writes `wdata_i` to the key register and does not touch the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Write target: 0 selects the reload register, 1 selects the key register |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| tick_i | input | 1 | Machine-cycle enable pulse |
| idle_i | input | 1 | Core idle indication (no effect on counting) |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with CNT_W=10 and the default PRE_W=7, which leaves three low bits. A full timeout is then 1024 ticks and each reload step is worth 8 ticks. This short count lets the bench sweep every legal reload value from 00h to 7Eh and check the exact tick on which each one fires, with the idle input toggling during the sweep. The same short count also makes the disable/resume, ignored-reload, same-cycle reload and wrap-to-zero cases affordable to run to overflow.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_KEY    = 1'b1
  } wsel_e;

  localparam logic [7:0] KEY_OFF_DEF = 8'h55;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 7,
  parameter logic [DATA_W-1:0] KEY_OFF = DATA_W'(KEY_OFF_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              load_o,
  output logic [PRE_W-1:0]  load_val_o,
  output logic              en_o
);
  localparam int unsigned RELOAD_MAX = (2 ** PRE_W) - 2;

  logic [DATA_W-1:0] key_q;
  logic              key_wr;

  assign key_wr     = wr_i && (wsel_e'(sel_i) == SEL_KEY);
  assign load_o     = wr_i && (wsel_e'(sel_i) == SEL_RELOAD)
                      && (wdata_i <= DATA_W'(RELOAD_MAX));
  assign load_val_o = wdata_i[PRE_W-1:0];
  assign en_o       = (key_q != KEY_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (key_wr) key_q <= wdata_i;
  end

  AST_KEY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (en_o == ($past(wdata_i) != KEY_OFF))); // R10
  AST_RELOAD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (wdata_i < DATA_W'(RELOAD_MAX + 1))); // R5
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] load_val_i,
  output logic             ovf_o
);
  localparam int unsigned LOW_W = CNT_W - PRE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = en_i && tick_i && !load_i;
  assign ovf_o = step && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= {load_val_i, {LOW_W{1'b0}}};  // reload wins over tick
    else if (step)    cnt_q <= cnt_q + 1'b1;                 // wraps to zero on overflow
  end

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q)); // R6
  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !load_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0)); // R2
  AST_LOAD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((cnt_q[CNT_W-1 -: PRE_W] == $past(load_val_i)) && (cnt_q[LOW_W-1:0] == '0))); // R3
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic req_o
);
  localparam int unsigned PC_W = $clog2(LEN + 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (trig_i)     pc_q <= PC_W'(LEN);
    else if (pc_q != '0) pc_q <= pc_q - 1'b1;
  end

  assign req_o = (pc_q != '0);

  AST_TRIG_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> req_o); // R2
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && (pc_q > PC_W'(1))) |=> req_o); // R2
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 22,
  parameter int unsigned PRE_W     = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_LEN = 4,
  parameter logic [DATA_W-1:0] KEY_OFF = DATA_W'(KEY_OFF_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              idle_i,
  output logic              rst_req_o
);
  logic             load;
  logic [PRE_W-1:0] load_val;
  logic             en;
  logic             ovf;
  logic             unused_idle;

  assign unused_idle = idle_i;  // counting continues in idle

  wdog_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .KEY_OFF(KEY_OFF)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .wdata_i,
    .load_o(load), .load_val_o(load_val), .en_o(en)
  );

  wdog_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .en_i(en), .load_i(load),
    .load_val_i(load_val), .ovf_o(ovf)
  );

  wdog_stretch #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .trig_i(ovf), .req_o(rst_req_o)
  );

  AST_NO_REQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !rst_req_o) |=> !rst_req_o); // R6
endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 10;
  localparam int LOWW = 3;
  localparam int FULL = 1 << CW;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       tick_i = 1'b0;
  logic       idle_i = 1'b0;
  logic       rst_req_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdog_top #(.CNT_W(CW)) uut (
    .clk_i, .rst_ni, .sel_i, .wr_i, .wdata_i, .tick_i, .idle_i, .rst_req_o
  );

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic write(input logic s, input logic [7:0] d);
    sel_i = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // n ticks to overflow: quiet before, 4-cycle pulse after
  task automatic expect_fire(input int n, input string tag);
    if (n > 1) ticks(n - 1);
    check(rst_req_o, 1'b0, {tag, " before overflow"});
    ticks(1);
    check(rst_req_o, 1'b1, {tag, " R2 pulse start"});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(rst_req_o, 1'b1, {tag, " R2 pulse hold"});
    end
    @(negedge clk_i);
    check(rst_req_o, 1'b0, {tag, " R2 pulse end"});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(rst_req_o, 1'b0, "R2 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: key resets enabled; R1 full count from zero
    expect_fire(FULL, "R7 R1 from reset");
    // R2: counter back at zero after overflow
    expect_fire(FULL, "R2 wrap");

    // R3 R8: sweep every legal reload value, idle toggling
    for (int v = 0; v <= 126; v++) begin
      idle_i = v[0];
      write(1'b0, 8'(v));
      expect_fire(FULL - (v << LOWW), "R3 R8 sweep");
    end
    idle_i = 1'b0;

    // R4: reload 00h mid count clears counter
    write(1'b0, 8'h40);
    ticks(300);
    write(1'b0, 8'h00);
    expect_fire(FULL, "R4 clear");

    // R5: out-of-range reload values ignored
    write(1'b0, 8'h40);
    ticks(100);
    write(1'b0, 8'h7F);
    ticks(100);
    write(1'b0, 8'h80);
    write(1'b0, 8'hFF);
    expect_fire(512 - 200, "R5 ignored");

    // R6 R7: disable holds count, other key resumes
    write(1'b0, 8'h00);
    ticks(500);
    write(1'b1, 8'h55);
    ticks(2000);
    check(rst_req_o, 1'b0, "R6 disabled no request");
    write(1'b1, 8'hAA);
    expect_fire(FULL - 500, "R7 resume");

    // R9: reload and tick in same cycle, reload wins
    write(1'b0, 8'h00);
    ticks(300);
    tick_i = 1'b1;
    write(1'b0, 8'h40);
    tick_i = 1'b0;
    expect_fire(512, "R9 reload wins");

    // R10: key write does not touch counter
    write(1'b0, 8'h00);
    ticks(600);
    write(1'b1, 8'h10);
    expect_fire(FULL - 600, "R10 key select");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule